// File: doc/BRIEF.md
# Per-Channel Color Lookup Translator

This block sits in a pixel path and remaps each color component of every incoming pixel through a programmable table. Red, green and blue each have their own table and their own enable. A channel whose enable is clear forwards its component unchanged. The translated pixel appears one clock after the input. Its sync and data-enable signals are delayed by the same clock, so the timing of the stream is kept.

Table contents are undefined after power-up, so the block holds software to a fixed order. Software first loads a table through the register port, then reads the table back to confirm it, and only then sets that channel's enable. While a channel is enabled, or still active until the next frame, its table is locked. Writes to a locked table are dropped and reads from it return zero. An enable change is staged, and it is applied only on the rising edge of vertical sync, so no frame is ever partly translated.

Top module: `color_lut_xlat`

## Requirements
- R1: After reset, all pixel and sync outputs are 0, `cfg_rdata` is 0, and both the requested and the active enables are clear.
- R2: A channel whose active enable is 0 outputs its input component unchanged, one clock later.
- R3: A channel whose active enable is 1 outputs the table entry addressed by its input component, one clock later.
- R4: The channels are independent. Red, green and blue use separate tables (`cfg_sel` 0, 1 and 2), and the enable of one channel never affects another.
- R5: `out_vsync`, `out_hsync` and `out_de` equal `pix_vsync`, `pix_hsync` and `pix_de` delayed by exactly one clock.
- R6: A write to the enable register (`cfg_sel`=3) changes only the requested enables. The active enables load the requested value at the clock edge where `pix_vsync` is 1 and was 0 on the previous edge, and at no other time.
- R7: A read of an unlocked table (`cfg_rd`=1, `cfg_sel` 0 to 2) places the entry at `cfg_addr` on `cfg_rdata` one clock later.
- R8: A channel is locked while its requested or its active enable is set. A table read of a locked channel returns 0.
- R9: A table write to a locked channel is ignored, so the entry keeps its previous value.
- R10: A read with `cfg_sel`=3 returns the requested enables in `cfg_rdata[2:0]` as {blue, green, red}, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_vsync | input | 1 | Input vertical sync; its rising edge is the frame boundary |
| pix_hsync | input | 1 | Input horizontal sync |
| pix_de | input | 1 | Input data enable |
| pix_r | input | COMP_W | Input red component |
| pix_g | input | COMP_W | Input green component |
| pix_b | input | COMP_W | Input blue component |
| out_vsync | output | 1 | Delayed vertical sync |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_de | output | 1 | Delayed data enable |
| out_r | output | COMP_W | Output red component |
| out_g | output | COMP_W | Output green component |
| out_b | output | COMP_W | Output blue component |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_sel | input | 2 | Target: 0 red table, 1 green table, 2 blue table, 3 enable register |
| cfg_addr | input | COMP_W | Table entry index |
| cfg_wdata | input | COMP_W | Write data; for the enable register, bits [2:0] are {blue, green, red} |
| cfg_rdata | output | COMP_W | Read data, registered |

## Verification
The bench builds the block with its default `COMP_W` of 8, which gives three full 256-entry tables. With that setting every entry of every table is written with a distinct computed pattern and read back, including both end indices. It also means a translated component can never be confused with its own pass-through value by accident. Frame-boundary timing, lock behaviour and mixed per-channel enables are driven against those same tables.

// File: rtl/color_lut_pkg.sv
package color_lut_pkg;
   localparam int NUM_CH = 3;

   typedef enum logic [1:0] {
      SEL_RED    = 2'd0,
      SEL_GREEN  = 2'd1,
      SEL_BLUE   = 2'd2,
      SEL_ENABLE = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/lut_bank.sv
module lut_bank #(
   parameter int COMP_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [COMP_W-1:0] wr_addr,
   input  logic [COMP_W-1:0] wr_data,
   input  logic [COMP_W-1:0] cfg_addr,
   output logic [COMP_W-1:0] cfg_data,
   input  logic [COMP_W-1:0] px_in,
   output logic [COMP_W-1:0] px_map
);
   localparam int DEPTH = 1 << COMP_W;

   logic [COMP_W-1:0] mem [DEPTH];

   // contents are left undefined at reset on purpose
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign cfg_data = mem[cfg_addr];
   assign px_map   = mem[px_in];
endmodule

// File: rtl/frame_enable.sv
module frame_enable #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vsync,
   input  logic         set_we,
   input  logic [N-1:0] set_val,
   output logic [N-1:0] req_en,
   output logic [N-1:0] act_en
);
   logic vs_q;
   logic frame_edge;

   assign frame_edge = vsync & ~vs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q   <= 1'b0;
         req_en <= '0;
         act_en <= '0;
      end else begin
         vs_q <= vsync;
         if (set_we)     req_en <= set_val;
         if (frame_edge) act_en <= req_en;
      end
   end
endmodule

// File: rtl/color_lut_xlat.sv
module color_lut_xlat
   import color_lut_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_vsync,
   input  logic              pix_hsync,
   input  logic              pix_de,
   input  logic [COMP_W-1:0] pix_r,
   input  logic [COMP_W-1:0] pix_g,
   input  logic [COMP_W-1:0] pix_b,
   output logic              out_vsync,
   output logic              out_hsync,
   output logic              out_de,
   output logic [COMP_W-1:0] out_r,
   output logic [COMP_W-1:0] out_g,
   output logic [COMP_W-1:0] out_b,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [1:0]        cfg_sel,
   input  logic [COMP_W-1:0] cfg_addr,
   input  logic [COMP_W-1:0] cfg_wdata,
   output logic [COMP_W-1:0] cfg_rdata
);
   // the enable register needs one bit per channel; the depth stays modest
   if (COMP_W < NUM_CH || COMP_W > 12) begin : g_bad_width
      $error("color_lut_xlat: COMP_W must lie in %0d..12", NUM_CH);
   end

   logic [COMP_W-1:0] px_in   [NUM_CH];
   logic [COMP_W-1:0] px_map  [NUM_CH];
   logic [COMP_W-1:0] px_sel  [NUM_CH];
   logic [COMP_W-1:0] rd_word [NUM_CH];
   logic [NUM_CH-1:0] req_en;
   logic [NUM_CH-1:0] act_en;
   logic [NUM_CH-1:0] lock;
   logic              en_we;

   assign px_in[0] = pix_r;
   assign px_in[1] = pix_g;
   assign px_in[2] = pix_b;
   assign lock     = req_en | act_en;
   assign en_we    = cfg_wr && (cfg_sel == SEL_ENABLE);

   frame_enable #(.N(NUM_CH)) u_frame_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .vsync   (pix_vsync),
      .set_we  (en_we),
      .set_val (cfg_wdata[NUM_CH-1:0]),
      .req_en  (req_en),
      .act_en  (act_en)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic wr_ok;
      assign wr_ok = cfg_wr && (cfg_sel == 2'(c)) && !lock[c];

      lut_bank #(.COMP_W(COMP_W)) u_bank (
         .clk      (clk),
         .wr_en    (wr_ok),
         .wr_addr  (cfg_addr),
         .wr_data  (cfg_wdata),
         .cfg_addr (cfg_addr),
         .cfg_data (rd_word[c]),
         .px_in    (px_in[c]),
         .px_map   (px_map[c])
      );

      assign px_sel[c] = act_en[c] ? px_map[c] : px_in[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vsync <= 1'b0;
         out_hsync <= 1'b0;
         out_de    <= 1'b0;
         out_r     <= '0;
         out_g     <= '0;
         out_b     <= '0;
      end else begin
         out_vsync <= pix_vsync;
         out_hsync <= pix_hsync;
         out_de    <= pix_de;
         out_r     <= px_sel[0];
         out_g     <= px_sel[1];
         out_b     <= px_sel[2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rdata <= '0;
      end else if (cfg_rd) begin
         if (cfg_sel == SEL_ENABLE)
            cfg_rdata <= COMP_W'(req_en);
         else if (lock[cfg_sel])
            cfg_rdata <= '0;
         else
            cfg_rdata <= rd_word[cfg_sel];
      end
   end
endmodule

// File: rtl/color_lut_xlat_chk.sv
module color_lut_xlat_chk #(
   parameter int COMP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_vsync,
   input logic              pix_hsync,
   input logic              pix_de,
   input logic [COMP_W-1:0] pix_r,
   input logic [COMP_W-1:0] pix_g,
   input logic [COMP_W-1:0] pix_b,
   input logic              out_vsync,
   input logic              out_hsync,
   input logic              out_de,
   input logic [COMP_W-1:0] out_r,
   input logic [COMP_W-1:0] out_g,
   input logic [COMP_W-1:0] out_b,
   input logic              cfg_rd,
   input logic [1:0]        cfg_sel,
   input logic [COMP_W-1:0] cfg_rdata,
   input logic [2:0]        req_en,
   input logic [2:0]        act_en
);
   logic [2:0] lock_v;
   assign lock_v = req_en | act_en;

   p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (out_vsync == $past(pix_vsync) && out_hsync == $past(pix_hsync)
                 && out_de == $past(pix_de)));

   p_pass_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !act_en[0]) |=> (out_r == $past(pix_r)));

   p_pass_green_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !act_en[1]) |=> (out_g == $past(pix_g)));

   p_pass_blue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !act_en[2]) |=> (out_b == $past(pix_b)));

   p_frame_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en != $past(act_en)) |-> ($past(pix_vsync) && !$past(pix_vsync, 2)));

   p_locked_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_sel != 2'd3 && lock_v[cfg_sel]) |=> (cfg_rdata == '0));

   p_enable_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_sel == 2'd3) |=> (cfg_rdata[COMP_W-1:3] == '0));
endmodule

bind color_lut_xlat color_lut_xlat_chk #(.COMP_W(COMP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_vsync (pix_vsync),
   .pix_hsync (pix_hsync),
   .pix_de    (pix_de),
   .pix_r     (pix_r),
   .pix_g     (pix_g),
   .pix_b     (pix_b),
   .out_vsync (out_vsync),
   .out_hsync (out_hsync),
   .out_de    (out_de),
   .out_r     (out_r),
   .out_g     (out_g),
   .out_b     (out_b),
   .cfg_rd    (cfg_rd),
   .cfg_sel   (cfg_sel),
   .cfg_rdata (cfg_rdata),
   .req_en    (req_en),
   .act_en    (act_en)
);

// File: tb/color_lut_xlat_tb.sv
module color_lut_xlat_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int DEPTH = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pix_vsync = 0, pix_hsync = 0, pix_de = 0;
   logic [W-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
   logic         out_vsync, out_hsync, out_de;
   logic [W-1:0] out_r, out_g, out_b;
   logic         cfg_wr = 0, cfg_rd = 0;
   logic [1:0]   cfg_sel = '0;
   logic [W-1:0] cfg_addr = '0, cfg_wdata = '0;
   logic [W-1:0] cfg_rdata;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   color_lut_xlat #(.COMP_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .pix_vsync(pix_vsync), .pix_hsync(pix_hsync), .pix_de(pix_de),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .out_vsync(out_vsync), .out_hsync(out_hsync), .out_de(out_de),
      .out_r(out_r), .out_g(out_g), .out_b(out_b),
      .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   function automatic logic [W-1:0] pattern(int c, int i);
      return W'((i * (2 * c + 3) + 17 * c + 5) & (DEPTH - 1));
   endfunction

   function automatic logic [W-1:0] xl(int c, logic en, logic [W-1:0] v);
      return en ? pattern(c, int'(v)) : v;
   endfunction

   task automatic check(input int got, input int exp, input string tag);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // advance one edge and settle away from it
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [W-1:0] a, input logic [W-1:0] d);
      cfg_sel = sel; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      step();
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [1:0] sel, input logic [W-1:0] a, output logic [W-1:0] d);
      cfg_sel = sel; cfg_addr = a; cfg_rd = 1'b1;
      step();
      d = cfg_rdata;
      cfg_rd = 1'b0;
   endtask

   // drive one pixel and compare the result one clock later
   task automatic pixel(input logic [W-1:0] r, input logic [W-1:0] g, input logic [W-1:0] b,
                        input logic de, input logic hs, input logic [2:0] en, input string tag);
      pix_r = r; pix_g = g; pix_b = b; pix_de = de; pix_hsync = hs;
      step();
      check(out_r, xl(0, en[0], r), {tag, " red"});
      check(out_g, xl(1, en[1], g), {tag, " green"});
      check(out_b, xl(2, en[2], b), {tag, " blue"});
      check(out_de, de, "R5 de");
      check(out_hsync, hs, "R5 hsync");
   endtask

   task automatic frame_edge();
      pix_vsync = 1'b1; pix_de = 1'b0;
      step();
      check(out_vsync, 1, "R5 vsync high");
      pix_vsync = 1'b0;
      step();
      check(out_vsync, 0, "R5 vsync low");
   endtask

   task automatic t_reset();
      logic [W-1:0] d;
      check(out_r, 0, "R1 out_r");
      check(out_g, 0, "R1 out_g");
      check(out_b, 0, "R1 out_b");
      check(out_de, 0, "R1 out_de");
      check(out_vsync, 0, "R1 out_vsync");
      check(cfg_rdata, 0, "R1 cfg_rdata");
      cfg_read(2'd3, '0, d);
      check(d, 0, "R1 R10 enables clear");
   endtask

   task automatic t_program_readback();
      logic [W-1:0] d;
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < DEPTH; i++) cfg_write(2'(c), W'(i), pattern(c, i));
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < DEPTH; i++) begin
            cfg_read(2'(c), W'(i), d);
            check(d, pattern(c, i), "R7 R4 table readback");
         end
   endtask

   task automatic t_passthrough();
      for (int k = 0; k < 12; k++)
         pixel(W'(k * 21), W'(255 - k * 7), W'(k * 13 + 1), k[0], k[1], 3'b000, "R2 pass");
      pixel('0, '0, '0, 1, 0, 3'b000, "R2 zero");
      pixel('1, '1, '1, 1, 1, 3'b000, "R2 max");
   endtask

   task automatic t_enable_at_frame();
      logic [W-1:0] d;
      cfg_write(2'd3, '0, W'(3'b010));
      cfg_read(2'd3, '0, d);
      check(d, 3'b010, "R10 enable readback");
      pixel(8'h40, 8'h41, 8'h42, 1, 0, 3'b000, "R6 before frame");
      frame_edge();
      for (int k = 0; k < 8; k++)
         pixel(W'(k * 31), W'(k * 29 + 3), W'(k * 17), 1, 0, 3'b010, "R3 R4 green only");
      pixel('0, '0, '1, 1, 0, 3'b010, "R3 ends");
      pixel('1, '1, '0, 1, 0, 3'b010, "R3 ends");
   endtask

   task automatic t_locked_access();
      logic [W-1:0] d;
      cfg_read(2'd1, 8'd10, d);
      check(d, 0, "R8 locked read green");
      cfg_read(2'd0, 8'd10, d);
      check(d, pattern(0, 10), "R8 R4 red unlocked");
      cfg_write(2'd1, 8'd10, ~pattern(1, 10));
      cfg_write(2'd3, '0, '0);
      cfg_read(2'd1, 8'd10, d);
      check(d, 0, "R8 still active until frame");
      pixel(8'h01, 8'd10, 8'h02, 1, 0, 3'b010, "R6 disable pending");
      frame_edge();
      cfg_read(2'd1, 8'd10, d);
      check(d, pattern(1, 10), "R9 locked write ignored");
      pixel(8'h01, 8'd10, 8'h02, 1, 0, 3'b000, "R6 disable applied");
   endtask

   task automatic t_all_enabled();
      cfg_write(2'd3, '0, W'(3'b111));
      pixel(8'h11, 8'h22, 8'h33, 1, 1, 3'b000, "R6 wait frame");
      frame_edge();
      for (int k = 0; k < 10; k++)
         pixel(W'(k * 25 + 4), W'(k * 9), W'(250 - k * 11), 1, k[0], 3'b111, "R3 all");
      cfg_write(2'd3, '0, '0);
      pixel(8'h80, 8'h81, 8'h82, 1, 0, 3'b111, "R6 hold to frame");
      frame_edge();
      pixel(8'h80, 8'h81, 8'h82, 1, 0, 3'b000, "R2 after disable");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
      t_reset();
      t_program_readback();
      t_passthrough();
      t_enable_at_frame();
      t_locked_access();
      t_all_enabled();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule